// File: doc/BRIEF.md
# 8-VSB Symbol Unpacker and Level Mapper

The block sits between a transmit word FIFO and the pulse-shaping filter of a vestigial-sideband modulator. It takes 32-bit words, each packing eight 4-bit symbol nibbles. It releases one symbol for every cycle in which an external symbol-rate strobe is high. Each 3-bit symbol code becomes one of eight odd amplitude levels. A constant positive DC pilot offset is added to every level, and the result is presented as a registered signed fixed-point sample with a valid flag.

Input words arrive over a valid/ready handshake. A single word buffer holds the word whose symbols are being sent. The next word is taken in the same cycle that the last symbol of the current word leaves, so a source that always has data ready gives a continuous symbol stream. When the strobe fires and no word is buffered, the block still produces a sample. That sample carries only the pilot, and an underflow flag is raised alongside it. This keeps the sample rate seen by the filter unbroken.

Top module: `vsb_symbol_unpacker`

## Requirements
- R1: Within a word, symbols leave lowest nibble first: the symbol in bits [3:0] goes first, then bits [7:4], and so on, with bits [31:28] going last.
- R2: Bit 3 of each nibble has no effect. Two words whose nibbles differ only in that bit produce identical sample sequences.
- R3: A code c (nibble bits [2:0]) gives the level 2c-7. The sample is that level times 4 plus 5, in two's complement with 8 bits and 2 fractional bits. This is the value 8c-23, ranging from -23 for code 0 to +33 for code 7.
- R4: sample_valid_o is high in exactly those cycles that follow a cycle with sym_en_i high. Each sample is registered, so it appears one clock after its strobe.
- R5: word_ready_o is high whenever the buffer is empty. When the buffer is full, it is high only in a cycle where sym_en_i is high while the eighth symbol of the held word is pending. A word is taken on a clock edge where word_valid_i and word_ready_o are both high.
- R6: If a new word is offered at every strobe that sends a last symbol, consecutive words produce symbols with no gap and no underflow.
- R7: A strobe that finds the buffer empty produces the pilot-only sample +5, with underflow_o and sample_valid_o both high for that one output cycle. A word taken at that same edge is sent starting with its first symbol at the next strobe.
- R8: Asynchronous active-low reset empties the buffer, returns the symbol index to the first nibble, and clears sample_valid_o, underflow_o and sample_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Packed word of eight symbol nibbles |
| word_valid_i | input | 1 | word_i holds a word |
| word_ready_o | output | 1 | Block accepts word_i on this edge |
| sym_en_i | input | 1 | Symbol-rate strobe |
| sample_o | output | 8 | Signed level plus pilot, 2 fractional bits |
| sample_valid_o | output | 1 | sample_o is a new symbol sample |
| underflow_o | output | 1 | Current sample carries only the pilot (buffer was empty) |

## Verification
Some properties are checked by the assertions on every cycle. The valid flag tracks the strobe one cycle later. An underflow sample is always the bare pilot value and is marked valid. Every non-underflow sample lies on the grid of odd levels scaled by 4 plus the pilot. An empty, idle buffer keeps offering ready. Other behaviour only shows over several cycles, so the bench's scenarios carry it: nibble order within a word, the don't-care top bit, gap-free hand-over between words, and the flush of a half-sent word on reset. The bench compares every sample with a queue of expected values built from the accepted words, and checks ready against the number of symbols left in the buffer.

// File: rtl/vsb_pkg.sv
`timescale 1ns/1ps
package vsb_pkg;
  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned SYM_W_DEF    = 4;
  localparam int unsigned CODE_W_DEF   = 3;
  localparam int unsigned SAMPLE_W_DEF = 8;
  localparam int unsigned FRAC_W_DEF   = 2;
  localparam int          PILOT_Q_DEF  = 5;  // +1.25 with 2 fractional bits

  typedef enum logic {BUF_EMPTY = 1'b0, BUF_FULL = 1'b1} buf_state_e;
endpackage

// File: rtl/vsb_word_buffer.sv
`timescale 1ns/1ps
module vsb_word_buffer
  import vsb_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SYM_W  = SYM_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              sym_en_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              sym_avail_o
);
  localparam int unsigned NSYM  = WORD_W / SYM_W;
  localparam int unsigned IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSYM - 1);

  buf_state_e        state_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SYM_W-1:0]  nib [NSYM];
  logic              last_sym;
  logic              accept;

  for (genvar g = 0; g < NSYM; g++) begin : g_nib
    assign nib[g] = word_q[g*SYM_W +: SYM_W];
  end

  assign last_sym     = (idx_q == LAST_IDX);
  assign word_ready_o = (state_q == BUF_EMPTY) || (sym_en_i && last_sym);
  assign accept       = word_valid_i && word_ready_o;
  assign sym_o        = nib[idx_q];
  assign sym_avail_o  = (state_q == BUF_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUF_EMPTY;
      word_q  <= '0;
      idx_q   <= '0;
    end else begin
      if (state_q == BUF_FULL && sym_en_i) begin
        idx_q <= last_sym ? '0 : idx_q + IDX_W'(1);
        if (last_sym) state_q <= BUF_EMPTY;
      end
      if (accept) begin
        word_q  <= word_i;
        idx_q   <= '0;
        state_q <= BUF_FULL;
      end
    end
  end
endmodule

// File: rtl/vsb_level_mapper.sv
`timescale 1ns/1ps
module vsb_level_mapper
  import vsb_pkg::*;
#(
  parameter int unsigned SYM_W    = SYM_W_DEF,
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned FRAC_W   = FRAC_W_DEF,
  parameter int          PILOT_Q  = PILOT_Q_DEF
) (
  input  logic [SYM_W-1:0]           sym_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int LVL_OFS = (1 << CODE_W) - 1;
  localparam int SCALE   = 1 << FRAC_W;

  logic [CODE_W-1:0] code;
  int                level;
  int                with_pilot;

  assign code = sym_i[CODE_W-1:0];

  if (SYM_W > CODE_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^sym_i[SYM_W-1:CODE_W];
  end

  always_comb begin
    level      = 2 * int'(code) - LVL_OFS;
    with_pilot = level * SCALE + PILOT_Q;
    sample_o   = SAMPLE_W'(with_pilot);
  end
endmodule

// File: rtl/vsb_sample_stage.sv
`timescale 1ns/1ps
module vsb_sample_stage
  import vsb_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int          PILOT_Q  = PILOT_Q_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sym_en_i,
  input  logic                       avail_i,
  input  logic signed [SAMPLE_W-1:0] level_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o,
  output logic                       underflow_o
);
  localparam logic signed [SAMPLE_W-1:0] PILOT_ONLY = SAMPLE_W'(PILOT_Q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o    <= '0;
      valid_o     <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      valid_o     <= sym_en_i;
      underflow_o <= sym_en_i && !avail_i;
      if (sym_en_i) sample_o <= avail_i ? level_i : PILOT_ONLY;
    end
  end
endmodule

// File: rtl/vsb_symbol_unpacker.sv
`timescale 1ns/1ps
module vsb_symbol_unpacker
  import vsb_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned SYM_W    = SYM_W_DEF,
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned FRAC_W   = FRAC_W_DEF,
  parameter int          PILOT_Q  = PILOT_Q_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                word_valid_i,
  output logic                word_ready_o,
  input  logic                sym_en_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                underflow_o
);
  logic [SYM_W-1:0]           cur_sym;
  logic                       sym_avail;
  logic signed [SAMPLE_W-1:0] mapped;
  logic signed [SAMPLE_W-1:0] sample_s;

  vsb_word_buffer #(.WORD_W(WORD_W), .SYM_W(SYM_W)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .sym_en_i     (sym_en_i),
    .sym_o        (cur_sym),
    .sym_avail_o  (sym_avail)
  );

  vsb_level_mapper #(
    .SYM_W(SYM_W), .CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W),
    .FRAC_W(FRAC_W), .PILOT_Q(PILOT_Q)
  ) u_map (
    .sym_i    (cur_sym),
    .sample_o (mapped)
  );

  vsb_sample_stage #(.SAMPLE_W(SAMPLE_W), .PILOT_Q(PILOT_Q)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_en_i    (sym_en_i),
    .avail_i     (sym_avail),
    .level_i     (mapped),
    .sample_o    (sample_s),
    .valid_o     (sample_valid_o),
    .underflow_o (underflow_o)
  );

  assign sample_o = sample_s;
endmodule

// File: rtl/vsb_unpacker_sva.sv
`timescale 1ns/1ps
module vsb_unpacker_sva #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned FRAC_W   = 2,
  parameter int          PILOT_Q  = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                word_valid_i,
  input logic                word_ready_o,
  input logic                sym_en_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_valid_o,
  input logic                underflow_o
);
  localparam int STEP  = 1 << (FRAC_W + 1);
  localparam int HALF  = 1 << FRAC_W;
  localparam int MAXAB = ((1 << CODE_W) - 1) * HALF;

  int   diff;
  logic on_grid;

  always_comb begin
    diff    = int'($signed(sample_o)) - PILOT_Q;
    on_grid = (((diff + 64 * STEP) % STEP) == HALF) && (diff <= MAXAB) && (diff >= -MAXAB);
  end

  // R4: valid exactly one cycle after each strobe
  a_r4_valid_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_en_i |=> sample_valid_o);
  a_r4_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_en_i |=> !sample_valid_o);

  // R7: underflow carries only the pilot and is a valid sample
  a_r7_underflow_pilot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (sample_valid_o && (int'($signed(sample_o)) == PILOT_Q)));

  // R3: data samples sit on the odd-level grid plus pilot
  a_r3_level_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && !underflow_o) |-> on_grid);

  // R5: an idle empty buffer keeps offering ready
  a_r5_empty_stays_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ready_o && !word_valid_i && !sym_en_i) |=> word_ready_o);

  // R8: outputs cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_clear: assert (!sample_valid_o && !underflow_o);
    end
  end
endmodule

bind vsb_symbol_unpacker vsb_unpacker_sva #(
  .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .FRAC_W(FRAC_W), .PILOT_Q(PILOT_Q)
) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .word_valid_i   (word_valid_i),
  .word_ready_o   (word_ready_o),
  .sym_en_i       (sym_en_i),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .underflow_o    (underflow_o)
);

// File: tb/vsb_symbol_unpacker_tb.sv
`timescale 1ns/1ps
module vsb_symbol_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic        sym_en_i = 1'b0;
  logic [7:0]  sample_o;
  logic        sample_valid_o;
  logic        underflow_o;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  logic will_en = 1'b0;
  logic will_acc = 1'b0;
  logic [31:0] acc_word = '0;
  int uf_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vsb_symbol_unpacker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .sym_en_i(sym_en_i), .sample_o(sample_o),
    .sample_valid_o(sample_valid_o), .underflow_o(underflow_o)
  );

  function automatic int exp_sample(input logic [31:0] w, input int k);
    int code;
    code = int'((w >> (4 * k)) & 32'h7);
    return 8 * code - 23;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Check outputs from previous edge, then update expected buffer contents
  task automatic observe();
    int s;
    s = int'($signed(sample_o));
    chk("R4 valid follows strobe", int'(sample_valid_o), int'(will_en));
    if (will_en) begin
      if (exp_q.size() > 0) begin
        chk("R1/R3 sample value", s, exp_q.pop_front());
        chk("R6 no underflow with data", int'(underflow_o), 0);
      end else begin
        uf_seen++;
        chk("R7 underflow flag", int'(underflow_o), 1);
        chk("R7 pilot-only sample", s, 5);
      end
    end else begin
      chk("R7 no underflow without strobe", int'(underflow_o), 0);
    end
    if (will_acc)
      for (int k = 0; k < 8; k++) exp_q.push_back(exp_sample(acc_word, k));
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic en);
    @(negedge clk);
    observe();
    word_valid_i = v;
    word_i = w;
    sym_en_i = en;
    #1;
    if (exp_q.size() == 0)      chk("R5 ready when empty", int'(word_ready_o), 1);
    else if (exp_q.size() == 1) chk("R5 ready on last symbol", int'(word_ready_o), int'(en));
    else                        chk("R5 not ready mid-word", int'(word_ready_o), 0);
    will_en  = en;
    will_acc = v && word_ready_o;
    acc_word = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    word_valid_i = 1'b0;
    sym_en_i = 1'b0;
    exp_q.delete();
    will_en = 1'b0;
    will_acc = 1'b0;
    #1;
    chk("R8 valid cleared in reset", int'(sample_valid_o), 0);
    chk("R8 underflow cleared in reset", int'(underflow_o), 0);
    chk("R8 sample cleared in reset", int'(sample_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    #1 rst_ni = 1'b0;
    #40;
    chk("R8 reset valid", int'(sample_valid_o), 0);
    chk("R8 reset ready", int'(word_ready_o), 1);
    rst_ni = 1'b1;

    // R1/R3: codes 0..7 in nibble order
    step(1'b1, 32'h7654_3210, 1'b0);
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b1);
    // R2: top bit of each nibble set, same codes
    step(1'b1, 32'hFEDC_BA98, 1'b0);
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b1);
    // R7: strobes with empty buffer
    uf_seen = 0;
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    chk("R7 underflows seen", uf_seen, 2);
    // R7: word taken on an underflow strobe
    step(1'b1, 32'h1357_0246, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b1);

    // R6: back-to-back streaming, continuous strobe and 1-in-3 strobe
    step(1'b1, $urandom, 1'b0);
    uf_seen = 0;
    for (int i = 0; i < 200; i++) step(1'b1, $urandom, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, $urandom, (i % 3) == 0);
    chk("R6 no underflow while streaming", uf_seen, 0);

    // R8: reset mid-word flushes buffer
    step(1'b1, 32'h7777_7777, 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    do_reset();
    uf_seen = 0;
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    chk("R8 buffer empty after reset", uf_seen, 1);

    // Random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, $urandom, ($urandom % 3) == 0);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule